// File: doc/BRIEF.md
# Two-Wire Alternating-Phase Serial Deserializer

This block receives a self-clocked stream carried on two wires, where the wires swap roles from bit to bit. When line B falls, the level on line A is a data bit. When line A falls, the level on line B is a data bit. The captured bits go into two short shift chains, one for even bit positions and one for odd ones. Each finished byte appears on a parallel port with a single-cycle strobe. Both wires are synchronized and oversampled by a system clock that runs at least twenty times faster than the line toggle rate.

A bit is only committed when the opposite line falls next. If the same line falls again instead, the bit was not data but the start of a delimiter run, and it is dropped.

A delimiter holds line A low while line B falls a fixed number of times, and it ends when line A rises. The run length selects the event:
- three falls mark a frame start;
- four falls mark the start of the CRC bytes;
- five falls mark a frame end.

Every recognised delimiter clears the bit count. Start and CRC-start switch reception on, and frame-end switches it off. An error is reported in two cases:
- a frame ends in the middle of a byte;
- both lines fall in the same sample.

The error also switches reception off until the next start delimiter. A host uses the events to realign its own byte bookkeeping.

Top module: `tw_deser`

## Requirements
- R1: While reset is asserted and on the first cycles after it, byteValid, frameStart, crcStart, frameEnd and errFlag are low, byteData is zero, and reception is off.
- R2: A fall of line B captures the level of line A into the even bit positions (0, 2, 4, 6). A fall of line A captures the level of line B into the odd positions (1, 3, 5, 7). The first capture after a start or CRC-start delimiter is bit 0, so bytes are assembled least significant bit first.
- R3: byteValid is high for exactly one system clock, together with the completed byte. A byte is released by the fall of line B that follows its eighth bit. byteData does not change between strobes.
- R4: Line A held low, line B falling exactly 3 times, then line A rising, produces a one-cycle frameStart pulse, clears the bit count and switches reception on. At most one of frameStart, crcStart and frameEnd is high in any cycle.
- R5: The same pattern with exactly 4 falls of line B produces a one-cycle crcStart pulse, discards any partial byte, and keeps reception on.
- R6: The same pattern with exactly 5 falls of line B produces a one-cycle frameEnd pulse and switches reception off. The last full byte of the frame is still reported, with no error.
- R7: A frame-end delimiter that arrives while the bit count is not a multiple of 8 raises errFlag in the same cycle as frameEnd, and the partial byte is dropped.
- R8: A sample in which both lines fall together raises errFlag, clears the bit count, drops any uncommitted bit, and switches reception off.
- R9: While reception is off, no byteValid is produced, whatever bit traffic arrives.
- R10: Consecutive bytes within a frame are each reported once, with the correct value.
- R11: Runs of 2 falls, or 6 or more falls, followed by the held line rising, produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the line toggle rate |
| rstN | input | 1 | Active-low synchronous reset |
| lineA | input | 1 | Serial wire A, asynchronous |
| lineB | input | 1 | Serial wire B, asynchronous |
| byteData | output | BYTE_W | Last assembled byte |
| byteValid | output | 1 | One-cycle strobe for byteData |
| frameStart | output | 1 | Frame-start delimiter seen |
| crcStart | output | 1 | CRC-start delimiter seen |
| frameEnd | output | 1 | Frame-end delimiter seen |
| errFlag | output | 1 | Partial byte at frame end, or simultaneous falls |

## Verification
The hardest case to reach from the ports is a delimiter that begins just after data. There, the first fall of the delimiter line looks exactly like a normal alternating data bit.

The stimulus sends a byte and stops partway through a second group of bits. It then opens a CRC-start or frame-end run. This checks that the opening fall is rolled back, while the bit it released is kept, so that the byte count stays exact.

A simultaneous fall of both wires is produced by raising both lines and dropping them in the same cycle. Traffic that follows it must then stay silent until a new start run arrives.

// File: rtl/tw_deser_pkg.sv
package tw_deser_pkg;

  // Strobes handed from the frame control to the capture datapath.
  typedef struct packed {
    logic commit;    // write bitVal into the next bit position
    logic bitVal;    // value being committed
    logic clearCnt;  // restart byte assembly at bit 0
  } dpStrobe_t;

  typedef enum logic {
    LINE_A = 1'b0,
    LINE_B = 1'b1
  } lineSel_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lvl,
  output logic fallPulse,
  output logic risePulse
);

  logic [STAGES-1:0] chainQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainQ <= {STAGES{IDLE}};
      prevQ  <= IDLE;
    end else begin
      chainQ <= {chainQ[STAGES-2:0], lineIn};
      prevQ  <= chainQ[STAGES-1];
    end
  end

  assign lvl       = chainQ[STAGES-1];
  assign fallPulse = prevQ & ~lvl;
  assign risePulse = ~prevQ & lvl;

endmodule

// File: rtl/tw_capture_dp.sv
module tw_capture_dp
  import tw_deser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              cntZero
);

  localparam int HALF  = BYTE_W / 2;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]       bitCnt;
  logic [1:0][HALF-1:0]   bankQ;
  logic [1:0][HALF-1:0]   bankNext;
  logic [BYTE_W-1:0]      assembled;

  // Each chain shifts toward bit 0, so its oldest bit ends up lowest.
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      if (strobe.commit && (bitCnt[0] == 1'(k)))
        bankNext[k] = {strobe.bitVal, bankQ[k][HALF-1:1]};
      else
        bankNext[k] = bankQ[k];
    end
  end

  // Interleave: chain 0 holds even positions, chain 1 odd positions.
  always_comb begin
    for (int j = 0; j < HALF; j++) begin
      for (int k = 0; k < 2; k++) begin
        assembled[2*j + k] = bankNext[k][j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      bankQ     <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      bankQ     <= bankNext;
      if (strobe.clearCnt) begin
        bitCnt <= '0;
      end else if (strobe.commit) begin
        if (bitCnt == LAST_BIT) begin
          bitCnt    <= '0;
          byteData  <= assembled;
          byteValid <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign cntZero = (bitCnt == '0);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (byteData != $past(byteData)) |-> byteValid); // R3

endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
  import tw_deser_pkg::*;
#(
  parameter int START_RUN = 3,
  parameter int CRC_RUN   = 4,
  parameter int END_RUN   = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lvlA,
  input  logic      lvlB,
  input  logic      fallA,
  input  logic      fallB,
  input  logic      riseA,
  input  logic      riseB,
  input  logic      cntZero,
  output dpStrobe_t strobe,
  output logic      frameStart,
  output logic      crcStart,
  output logic      frameEnd,
  output logic      errFlag
);

  localparam int RUN_TOP = maxOf3(START_RUN, CRC_RUN, END_RUN) + 1;
  localparam int RUN_W   = $clog2(RUN_TOP + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_TOP);

  lineSel_t         lastLine;
  logic [RUN_W-1:0] runLen;
  logic             pendValid;
  logic             pendBit;
  logic             rxEn;

  logic     bothFall, oneFall, riseOther, closeRun;
  logic     hitStart, hitCrc, hitEnd, hitAny;
  logic     sameLine, freshFall;
  lineSel_t fLine;

  always_comb begin
    bothFall  = fallA & fallB;
    oneFall   = fallA ^ fallB;
    fLine     = fallB ? LINE_B : LINE_A;
    riseOther = (lastLine == LINE_A) ? riseB : riseA;
    closeRun  = riseOther && (runLen >= RUN_W'(2)) && !bothFall;
    hitStart  = closeRun && (runLen == RUN_W'(START_RUN));
    hitCrc    = closeRun && (runLen == RUN_W'(CRC_RUN));
    hitEnd    = closeRun && (runLen == RUN_W'(END_RUN));
    hitAny    = hitStart || hitCrc || hitEnd;
    sameLine  = oneFall && (fLine == lastLine) && (runLen != '0);
    freshFall = oneFall && !sameLine && !closeRun;

    strobe.commit   = freshFall && pendValid && rxEn;
    strobe.bitVal   = pendBit;
    strobe.clearCnt = bothFall || hitAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLine   <= LINE_A;
      runLen     <= RUN_W'(1);
      pendValid  <= 1'b0;
      pendBit    <= 1'b0;
      rxEn       <= 1'b0;
      frameStart <= 1'b0;
      crcStart   <= 1'b0;
      frameEnd   <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      crcStart   <= 1'b0;
      frameEnd   <= 1'b0;
      errFlag    <= 1'b0;
      if (bothFall) begin
        errFlag   <= 1'b1;
        rxEn      <= 1'b0;
        pendValid <= 1'b0;
        lastLine  <= LINE_A;
        runLen    <= RUN_W'(1);
      end else if (closeRun) begin
        pendValid <= 1'b0;
        if (hitAny) begin
          lastLine   <= (lastLine == LINE_A) ? LINE_B : LINE_A;
          runLen     <= RUN_W'(1);
          frameStart <= hitStart;
          crcStart   <= hitCrc;
          frameEnd   <= hitEnd;
          errFlag    <= hitEnd && !cntZero;
          if (hitStart || hitCrc) rxEn <= 1'b1;
          else                    rxEn <= 1'b0;
        end else begin
          runLen <= '0;
        end
      end else if (freshFall) begin
        pendValid <= 1'b1;
        pendBit   <= (fLine == LINE_B) ? lvlA : lvlB;
        lastLine  <= fLine;
        runLen    <= RUN_W'(1);
      end else if (sameLine) begin
        pendValid <= 1'b0;
        if (runLen != RUN_SAT) runLen <= runLen + 1'b1;
      end
    end
  end

  AST_BOTH_FALL_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (fallA && fallB) |=> errFlag); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, crcStart, frameEnd})); // R4

endmodule

// File: rtl/tw_deser.sv
module tw_deser
  import tw_deser_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int START_RUN   = 3,
  parameter int CRC_RUN     = 4,
  parameter int END_RUN     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineA,
  input  logic              lineB,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              frameStart,
  output logic              crcStart,
  output logic              frameEnd,
  output logic              errFlag
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] lineVec;
  logic [NUM_LINES-1:0] lvlVec, fallVec, riseVec;
  dpStrobe_t            strobe;
  logic                 cntZero;

  assign lineVec = {lineB, lineA};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    tw_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .lineIn   (lineVec[g]),
      .lvl      (lvlVec[g]),
      .fallPulse(fallVec[g]),
      .risePulse(riseVec[g])
    );
  end

  tw_frame_ctrl #(
    .START_RUN(START_RUN),
    .CRC_RUN  (CRC_RUN),
    .END_RUN  (END_RUN)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lvlA      (lvlVec[0]),
    .lvlB      (lvlVec[1]),
    .fallA     (fallVec[0]),
    .fallB     (fallVec[1]),
    .riseA     (riseVec[0]),
    .riseB     (riseVec[1]),
    .cntZero   (cntZero),
    .strobe    (strobe),
    .frameStart(frameStart),
    .crcStart  (crcStart),
    .frameEnd  (frameEnd),
    .errFlag   (errFlag)
  );

  tw_capture_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .byteData (byteData),
    .byteValid(byteValid),
    .cntZero  (cntZero)
  );

  AST_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !byteValid); // R7

endmodule

// File: tb/tw_deser_test.sv
module tw_deser_test;

  localparam int STEP = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineA = 1'b1;
  logic       lineB = 1'b1;
  logic [7:0] byteData;
  logic       byteValid, frameStart, crcStart, frameEnd, errFlag;

  int total = 0;
  int bad   = 0;

  int         nByte, nStart, nCrc, nEnd, nErr;
  logic [7:0] log [16];

  always #2 clk = ~clk;

  tw_deser uut (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB),
    .byteData(byteData), .byteValid(byteValid), .frameStart(frameStart),
    .crcStart(crcStart), .frameEnd(frameEnd), .errFlag(errFlag)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (nByte < 16) log[nByte] = byteData;
        nByte++;
      end
      if (frameStart) nStart++;
      if (crcStart)   nCrc++;
      if (frameEnd)   nEnd++;
      if (errFlag)    nErr++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    nByte = 0; nStart = 0; nCrc = 0; nEnd = 0; nErr = 0;
  endtask

  task automatic waitStep();
    repeat (STEP) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input int idx, input logic val);
    if (idx % 2 == 0) begin
      lineA = val; waitStep();
      lineB = 1'b1; waitStep();
      lineB = 1'b0; waitStep();
    end else begin
      lineB = val; waitStep();
      lineA = 1'b1; waitStep();
      lineA = 1'b0; waitStep();
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(i, v[i]);
  endtask

  task automatic sendDelim(input int falls);
    lineA = 1'b0; waitStep();
    for (int i = 0; i < falls; i++) begin
      lineB = 1'b1; waitStep();
      lineB = 1'b0; waitStep();
    end
    lineA = 1'b1; waitStep();
    waitStep();
  endtask

  task automatic testReset();
    check(byteValid == 0 && frameStart == 0 && crcStart == 0 && frameEnd == 0 && errFlag == 0,
          "R1 strobes after reset", {byteValid, frameStart, crcStart, frameEnd, errFlag}, 0);
    check(byteData == 8'h00, "R1 byteData after reset", byteData, 0);
  endtask

  task automatic testIdleTraffic();
    clearLog();
    sendByte(8'hA5);
    sendByte(8'h5A);
    waitStep();
    check(nByte == 0, "R9 no byte before start", nByte, 0);
  endtask

  task automatic testOddRuns();
    clearLog();
    sendDelim(2);
    sendDelim(6);
    check(nStart + nCrc + nEnd + nErr == 0, "R11 unrecognised runs", nStart + nCrc + nEnd + nErr, 0);
    sendByte(8'h3C);
    sendByte(8'h11);
    check(nByte == 0, "R11 reception still off", nByte, 0);
  endtask

  task automatic testFrame();
    logic [7:0] exp [5] = '{8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00};
    clearLog();
    sendDelim(3);
    check(nStart == 1, "R4 frameStart count", nStart, 1);
    foreach (exp[i]) sendByte(exp[i]);
    check(nByte == 4, "R3 last byte waits for next B fall", nByte, 4);
    sendDelim(5);
    check(nByte == 5, "R10 byte count", nByte, 5);
    for (int i = 0; i < 5; i++)
      check(log[i] == exp[i], "R2 byte value", log[i], exp[i]);
    check(nEnd == 1, "R6 frameEnd count", nEnd, 1);
    check(nErr == 0, "R6 no error on aligned end", nErr, 0);
    clearLog();
    sendByte(8'h96);
    sendByte(8'h69);
    check(nByte == 0, "R9 no byte after end", nByte, 0);
  endtask

  task automatic testCrc();
    clearLog();
    sendDelim(3);
    sendByte(8'h5A);
    sendBit(0, 1'b1);
    sendBit(1, 1'b0);
    sendBit(2, 1'b1);
    sendDelim(4);
    check(nCrc == 1, "R5 crcStart count", nCrc, 1);
    check(nByte == 1, "R5 partial not reported", nByte, 1);
    sendByte(8'hC3);
    sendDelim(5);
    check(nByte == 2, "R5 bytes after crc", nByte, 2);
    check(log[0] == 8'h5A, "R5 byte before crc", log[0], 8'h5A);
    check(log[1] == 8'hC3, "R5 byte realigned after crc", log[1], 8'hC3);
    check(nErr == 0, "R5 no error", nErr, 0);
  endtask

  task automatic testPartialEnd();
    clearLog();
    sendDelim(3);
    sendBit(0, 1'b1);
    sendBit(1, 1'b0);
    sendBit(2, 1'b1);
    sendBit(3, 1'b1);
    sendDelim(5);
    check(nEnd == 1, "R7 frameEnd seen", nEnd, 1);
    check(nErr == 1, "R7 error on partial byte", nErr, 1);
    check(nByte == 0, "R7 partial dropped", nByte, 0);
  endtask

  task automatic testBothFall();
    clearLog();
    sendDelim(3);
    sendByte(8'h11);
    lineA = 1'b1; lineB = 1'b1; waitStep();
    lineA = 1'b0; lineB = 1'b0; waitStep();
    waitStep();
    check(nErr == 1, "R8 error on joint fall", nErr, 1);
    check(nByte == 0, "R8 pending bit dropped", nByte, 0);
    sendByte(8'h22);
    sendByte(8'h44);
    check(nByte == 0, "R8 reception off after error", nByte, 0);
    clearLog();
    sendDelim(3);
    sendByte(8'h77);
    sendDelim(5);
    check(nByte == 1 && log[0] == 8'h77, "R8 recovery byte", log[0], 8'h77);
    check(nErr == 0, "R8 clean recovery", nErr, 0);
  endtask

  initial begin
    clearLog();
    repeat (5) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testIdleTraffic();
    testOddRuns();
    testFrame();
    testCrc();
    testPartialEnd();
    testBothFall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule